// File: doc/BRIEF.md
# Complementary PWM Deadtime Inserter

This block turns the raw outputs of three PWM generators into three complementary top/bottom pin pairs for half-bridge transistor stages. Outside a switching event exactly one transistor of a pair is commanded on. Whenever the signal feeding a pair changes level, both pins of that pair are pulled to the inactive (low) level for a programmable number of PWM clock cycles. Only then does the side that the new level selects switch on, so the slower turn-off of one transistor cannot overlap the turn-on of its partner.

Each pair has its own source select. It either passes the generator signal or substitutes a software-held level, and the deadtime logic treats both sources the same way. One 8-bit count sets the deadtime for rising and falling source edges alike. A count of zero removes the gap.

Each pair runs a three-state machine. `S_DEAD` holds both pins low while a down-counter runs. `S_TOP` drives the top pin, and `S_BOT` drives the bottom pin. The transitions are:
- **enter_dead**: from any state into `S_DEAD` when the source changes and the count is non-zero. The counter loads count minus one.
- **retrigger**: a source change inside `S_DEAD` reloads the counter.
- **tick**: in `S_DEAD` with no change and the counter above zero, the counter decrements.
- **expire**: from `S_DEAD` to `S_TOP` or `S_BOT` when the counter is zero and no change is seen. The registered source level picks the state.
- **bypass**: with a zero count, a source change goes straight to the state that matches the new level.
- **hold**: `S_TOP` and `S_BOT` stay where they are while the source is steady.

Top module: `pwm_deadtime_inserter`

## Requirements
- R1: Pair i (i = 0..2) is fed by bit i of `gen_in`. It drives `pwm_out[2*i]` as top and `pwm_out[2*i+1]` as bottom. Activity on one pair never changes another pair's pins.
- R2: The top and bottom pins of a pair are never high together.
- R3: Let a source change of a pair be sampled at clock edge k, with a non-zero count D. Both pins of the pair are low after edges k through k+D-1. From edge k+D, top is high if the new level is 1, and bottom is high if the new level is 0.
- R4: A further source change during the low interval restarts it. Both pins stay low until D edges have passed after the last change.
- R5: With a count of zero, a change sampled at edge k switches the pins directly after edge k: top equals the new level and bottom its inverse, with no low interval.
- R6: The count is captured when a change is sampled. Writing `dead_cycles` while a low interval runs does not alter that interval; the new value applies from the next change.
- R7: While `rst_n` is low, all six pins are low. The reference level of every source is 0 after reset, so with a source at 0 the bottom pin goes high at the first edge after reset release.
- R8: When `swctl_en[i]` is 1, pair i uses `swctl_val[i]` as its source, and `gen_in[i]` has no effect on its pins. When `swctl_en[i]` is 0, pair i uses `gen_in[i]`.
- R9: While a pair's source is steady and its low interval has expired, its pins do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_in | input | 3 | Raw generator signals, one per pair |
| dead_cycles | input | 8 | Deadtime length in clock cycles (0 = no gap) |
| swctl_en | input | 3 | Per-pair select: 1 = software level, 0 = generator |
| swctl_val | input | 3 | Per-pair software level |
| pwm_out | output | 6 | Pins; even bit = top, odd bit = bottom of each pair |

## Verification
The bench builds the block with its default three pairs and an 8-bit count, and keeps counts small (0 to 4). This makes an exhaustive sweep possible over every pair, every count in that range and every pulse width from 1 to 6 cycles. The sweep covers pulses shorter than, equal to and longer than the deadtime, and therefore every retrigger-versus-expire ordering. Directed cases then cover a count rewritten mid-interval, software override against a toggling generator, and reset release.

// File: rtl/dt_pkg.sv
package dt_pkg;
    typedef enum logic [1:0] {
        S_DEAD = 2'b00,
        S_TOP  = 2'b01,
        S_BOT  = 2'b10
    } dt_state_e;
endpackage

// File: rtl/dt_src_mux.sv
module dt_src_mux #(
    parameter int NUM_PAIRS = 3
) (
    input  logic [NUM_PAIRS-1:0] gen_in,
    input  logic [NUM_PAIRS-1:0] swctl_en,
    input  logic [NUM_PAIRS-1:0] swctl_val,
    output logic [NUM_PAIRS-1:0] pair_src
);
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_sel
        assign pair_src[i] = swctl_en[i] ? swctl_val[i] : gen_in[i];
    end
endmodule

// File: rtl/dt_pair_fsm.sv
module dt_pair_fsm
    import dt_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            top_on,
    output logic            bot_on
);
    localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};
    localparam logic [DT_W-1:0] CNT_ZERO = '0;

    dt_state_e       state_q, state_d;
    logic [DT_W-1:0] cnt_q, cnt_d;
    logic            src_q;
    logic            chg;

    assign chg = src ^ src_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_DEAD;
            cnt_q   <= CNT_ZERO;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            src_q   <= src;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_TOP, S_BOT: begin
                if (chg) begin
                    if (dead_cycles == CNT_ZERO) begin
                        state_d = src ? S_TOP : S_BOT;          // bypass
                    end else begin
                        state_d = S_DEAD;                       // enter_dead
                        cnt_d   = dead_cycles - CNT_ONE;
                    end
                end
            end
            S_DEAD: begin
                if (chg) begin
                    if (dead_cycles == CNT_ZERO) begin
                        state_d = src ? S_TOP : S_BOT;          // bypass
                    end else begin
                        cnt_d = dead_cycles - CNT_ONE;          // retrigger
                    end
                end else if (cnt_q == CNT_ZERO) begin
                    state_d = src_q ? S_TOP : S_BOT;            // expire
                end else begin
                    cnt_d = cnt_q - CNT_ONE;                    // tick
                end
            end
            default: begin
                state_d = S_DEAD;
                cnt_d   = CNT_ZERO;
            end
        endcase
    end

    // outputs
    always_comb begin
        top_on = 1'b0;
        bot_on = 1'b0;
        unique case (state_q)
            S_TOP:   top_on = 1'b1;
            S_BOT:   bot_on = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwm_deadtime_inserter.sv
module pwm_deadtime_inserter #(
    parameter int NUM_PAIRS = 3,
    parameter int DT_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PAIRS-1:0]   gen_in,
    input  logic [DT_W-1:0]        dead_cycles,
    input  logic [NUM_PAIRS-1:0]   swctl_en,
    input  logic [NUM_PAIRS-1:0]   swctl_val,
    output logic [2*NUM_PAIRS-1:0] pwm_out
);
    logic [NUM_PAIRS-1:0] pair_src;

    dt_src_mux #(.NUM_PAIRS(NUM_PAIRS)) i_mux (
        .gen_in    (gen_in),
        .swctl_en  (swctl_en),
        .swctl_val (swctl_val),
        .pair_src  (pair_src)
    );

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        dt_pair_fsm #(.DT_W(DT_W)) i_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .src         (pair_src[i]),
            .dead_cycles (dead_cycles),
            .top_on      (pwm_out[2*i]),
            .bot_on      (pwm_out[2*i+1])
        );
    end
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
    parameter int NUM_PAIRS = 3,
    parameter int DT_W      = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_PAIRS-1:0]   gen_in,
    input logic [DT_W-1:0]        dead_cycles,
    input logic [NUM_PAIRS-1:0]   swctl_en,
    input logic [NUM_PAIRS-1:0]   swctl_val,
    input logic [2*NUM_PAIRS-1:0] pwm_out
);
    logic [NUM_PAIRS-1:0] src_now, src_prev;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_src
        assign src_now[i] = swctl_en[i] ? swctl_val[i] : gen_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src_now;
    end

    // R7: pins low while reset is held
    always @(posedge clk) begin
        if (!rst_n) a_r7_reset_low: assert (pwm_out == '0);
    end

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_chk
        // R2
        a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
            !(pwm_out[2*i] && pwm_out[2*i+1]));
        // R3
        a_r3_gap_on_change: assert property (@(posedge clk) disable iff (!rst_n)
            ((src_now[i] != src_prev[i]) && (dead_cycles != '0))
            |=> (pwm_out[2*i] == 1'b0 && pwm_out[2*i+1] == 1'b0));
        // R5
        a_r5_zero_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            ((src_now[i] != src_prev[i]) && (dead_cycles == '0))
            |=> (pwm_out[2*i] == $past(src_now[i]) && pwm_out[2*i+1] == !$past(src_now[i])));
        // R9
        a_r9_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
            ((pwm_out[2*i] || pwm_out[2*i+1]) && (src_now[i] == src_prev[i]))
            |=> $stable(pwm_out[2*i+1:2*i]));
    end
endmodule

bind pwm_deadtime_inserter dt_checker #(.NUM_PAIRS(NUM_PAIRS), .DT_W(DT_W)) i_dt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .gen_in      (gen_in),
    .dead_cycles (dead_cycles),
    .swctl_en    (swctl_en),
    .swctl_val   (swctl_val),
    .pwm_out     (pwm_out)
);

// File: tb/test_pwm_deadtime_inserter.sv
module test_pwm_deadtime_inserter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] gen_in = '0;
    logic [7:0] dead_cycles = '0;
    logic [2:0] swctl_en = '0;
    logic [2:0] swctl_val = '0;
    logic [5:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [5:0] ALL_BOT = 6'b101010;

    always #4 clk = ~clk;

    pwm_deadtime_inserter i_pwm_deadtime_inserter (
        .clk, .rst_n, .gen_in, .dead_cycles, .swctl_en, .swctl_val, .pwm_out
    );

    task automatic check(input logic [5:0] exp, input string req);
        checks++;
        if (pwm_out !== exp) begin
            errors++;
            $display("FAIL %s: pwm_out=%b expected=%b at %0t", req, pwm_out, exp, $time);
        end
    endtask

    // pins for pair p set to {bot,top}, others bottom-on
    function automatic logic [5:0] vec(input int p, input bit top, input bit bot);
        logic [5:0] v = ALL_BOT;
        v[2*p]   = top;
        v[2*p+1] = bot;
        return v;
    endfunction

    task automatic step();
        @(posedge clk); #1;
    endtask

    // settle all sources to 0 with count d
    task automatic settle(input int d);
        @(negedge clk);
        gen_in = '0; swctl_en = '0; swctl_val = '0; dead_cycles = 8'(d);
        repeat (10) step();
        check(ALL_BOT, "R9 settled");
    endtask

    initial begin
        // R7: reset
        gen_in = 3'b101; dead_cycles = 8'd3;
        repeat (3) step();
        check(6'b000000, "R7 reset low");
        @(negedge clk);
        gen_in = '0; rst_n = 1'b1;
        step();
        check(ALL_BOT, "R7 first edge bottom");

        // R1 R3 R4 R5 sweep: pulse of width L on pair p, count D
        for (int p = 0; p < 3; p++) begin
            for (int d = 0; d <= 4; d++) begin
                for (int l = 1; l <= 6; l++) begin
                    settle(d);
                    for (int j = 0; j <= l + d + 2; j++) begin
                        @(negedge clk);
                        if (j == 0) gen_in[p] = 1'b1;
                        if (j == l) gen_in[p] = 1'b0;
                        step();
                        check(vec(p, (j >= d) && (j < l), j >= l + d),
                              (d == 0) ? "R5 zero count" : (l <= d ? "R4 retrigger" : "R3 R1 gap"));
                    end
                end
            end
        end

        // R6: count rewritten mid-interval
        settle(4);
        for (int j = 0; j <= 9; j++) begin
            @(negedge clk);
            if (j == 0) gen_in[0] = 1'b1;
            if (j == 1) dead_cycles = 8'd1;
            if (j == 6) gen_in[0] = 1'b0;
            step();
            check(vec(0, (j >= 4) && (j < 6), j >= 7), "R6 count captured");
        end

        // R8: software override, generator toggling ignored
        settle(2);
        for (int j = 0; j <= 12; j++) begin
            @(negedge clk);
            gen_in[1] = j[0];
            if (j == 0) begin swctl_en[1] = 1'b1; swctl_val[1] = 1'b1; end
            if (j == 8) begin swctl_en[1] = 1'b0; gen_in[1] = 1'b0; end
            if (j > 8) gen_in[1] = 1'b0;
            step();
            check(vec(1, (j >= 2) && (j < 8), j >= 10), "R8 override");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule